// File: doc/BRIEF.md
# Receive-Side Link Training Controller

This block brings up the receive end of a point-to-point serial link that has a back channel to the transmitter. It watches status flags from the analog front end: signal present, clock-recovery lock, training pattern seen, clock extraction finished and lane alignment finished. From these it walks a five-step handshake until the link is declared usable. While it waits for the far end to start training, it sends a short pulse upstream at a fixed interval. When it reaches the alignment step, it issues a one-cycle start command to the aligner.

A failure drops the link. Losing the incoming signal sends the controller back to idle. Losing lock while the signal is still present sends it back to the point where it asks for training again. Each acquisition step also has its own cycle budget, and running out of that budget has the same effect as losing lock. The handshake runs only while the enable input is high. With enable low, the controller rests in idle.

Top module: `lnk_train_ctrl`

## Requirements
- R1: After reset, `state_code` is 0 (idle) and `beacon_pulse`, `align_start` and `link_up` are all low.
- R2: While `enable` is low, the state is idle (code 0) from the next cycle on, whatever the other inputs do.
- R3: In idle with `enable` high, the controller moves to link detect (code 1) in the cycle after both `sig_det` and `cdr_lock` are high. Otherwise it stays idle.
- R4: `beacon_pulse` is high for one cycle in the first cycle of link detect. It is high again every `BEACON_PERIOD` cycles for as long as link detect lasts, and it is never high in any other state.
- R5: In link detect, the controller moves to clock acquisition (code 2) in the cycle after `train_seen` and `cdr_lock` are both high. It stays in link detect when lock is low, while the signal is present.
- R6: In clock acquisition, `xclk_done` moves the controller to link acquisition (code 3). `align_start` is high for exactly the first cycle of link acquisition.
- R7: In link acquisition, `align_done` moves the controller to normal (code 4). `link_up` is high exactly while the state is normal.
- R8: Clock acquisition lasts at most `CLK_ACQ_WINDOW` cycles and link acquisition at most `LNK_ACQ_WINDOW` cycles. When the budget runs out without the done flag, the controller returns to link detect. A done flag in the last cycle of the budget wins over the timeout.
- R9: Losing `sig_det` in any state other than idle returns the controller to idle in the next cycle. This takes precedence over a simultaneous loss of lock.
- R10: Losing `cdr_lock` while `sig_det` stays high, in clock acquisition, link acquisition or normal, returns the controller to link detect in the next cycle.
- R11: `state_code` encodes the states as idle 0, link detect 1, clock acquisition 2, link acquisition 3 and normal 4. The controller follows the sequence checked by the reference model under long random input streams.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Enables the training handshake |
| sig_det | input | 1 | Input signal present on the line |
| cdr_lock | input | 1 | Clock-recovery unit locked |
| train_seen | input | 1 | Training pattern detected |
| xclk_done | input | 1 | Clock extraction finished |
| align_done | input | 1 | Lane alignment finished |
| beacon_pulse | output | 1 | Periodic link-detect pulse to the back channel |
| align_start | output | 1 | One-cycle command that starts lane alignment |
| link_up | output | 1 | Link is in normal operation |
| state_code | output | 3 | Current state encoding |

## Verification
Two collisions need deliberate stimulus.

The first is a done flag that arrives in the last cycle of an acquisition budget. The bench counts the window down cycle by cycle and raises `align_done` exactly when the budget expires. It then expects normal, not link detect.

The second is signal loss and lock loss falling in the same cycle while the link is up. Here idle must win over link detect.

A long weighted random phase makes both collisions happen again and again. Every output is compared each cycle against the behavioural model's priority order.

// File: rtl/lnk_train_pkg.sv
package lnk_train_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_DETECT = 3'd1,
        ST_CLKACQ = 3'd2,
        ST_LNKACQ = 3'd3,
        ST_NORMAL = 3'd4
    } lt_state_e;

    typedef struct packed {
        lt_state_e state;
        logic      link_up;
    } lt_ctrl_s;

endpackage

// File: rtl/lnk_window_timer.sv
module lnk_window_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic expired,
    output logic first
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_s;

    tmr_s tm_d, tm_q;

    always_comb begin
        tm_d = tm_q;
        if (!active) begin
            tm_d.cnt = '0;
        end else if (tm_q.cnt != LAST) begin
            tm_d.cnt = tm_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tm_q <= '0;
        else        tm_q <= tm_d;
    end

    assign expired = active && (tm_q.cnt == LAST);
    assign first   = active && (tm_q.cnt == '0);

    AST_TMR_FRESH_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> first); // R8
    AST_TMR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (tm_q.cnt <= LAST)); // R8

endmodule

// File: rtl/lnk_beacon_gen.sv
module lnk_beacon_gen #(
    parameter int PERIOD = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic pulse
);
    generate
        if (PERIOD <= 1) begin : g_every
            assign pulse = active;
        end else begin : g_count
            localparam int BW = $clog2(PERIOD);
            localparam logic [BW-1:0] WRAP = BW'(PERIOD - 1);

            typedef struct packed {
                logic [BW-1:0] cnt;
            } bcn_s;

            bcn_s bc_d, bc_q;

            always_comb begin
                bc_d = bc_q;
                if (!active)             bc_d.cnt = '0;
                else if (bc_q.cnt == WRAP) bc_d.cnt = '0;
                else                     bc_d.cnt = bc_q.cnt + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) bc_q <= '0;
                else        bc_q <= bc_d;
            end

            assign pulse = active && (bc_q.cnt == '0);

            AST_BEACON_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
                pulse |=> !pulse); // R4
        end
    endgenerate

endmodule

// File: rtl/lnk_train_ctrl.sv
module lnk_train_ctrl
    import lnk_train_pkg::*;
#(
    parameter int BEACON_PERIOD  = 256,
    parameter int CLK_ACQ_WINDOW = 1024,
    parameter int LNK_ACQ_WINDOW = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       sig_det,
    input  logic       cdr_lock,
    input  logic       train_seen,
    input  logic       xclk_done,
    input  logic       align_done,
    output logic       beacon_pulse,
    output logic       align_start,
    output logic       link_up,
    output logic [2:0] state_code
);
    lt_ctrl_s ctl_d, ctl_q;

    logic in_detect, in_clkacq, in_lnkacq;
    logic clk_expired, clk_first_unused;
    logic lnk_expired, lnk_first;

    assign in_detect = (ctl_q.state == ST_DETECT);
    assign in_clkacq = (ctl_q.state == ST_CLKACQ);
    assign in_lnkacq = (ctl_q.state == ST_LNKACQ);

    lnk_beacon_gen #(.PERIOD(BEACON_PERIOD)) u_beacon (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (in_detect),
        .pulse  (beacon_pulse)
    );

    lnk_window_timer #(.LIMIT(CLK_ACQ_WINDOW)) u_clk_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (in_clkacq),
        .expired (clk_expired),
        .first   (clk_first_unused)
    );

    lnk_window_timer #(.LIMIT(LNK_ACQ_WINDOW)) u_lnk_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (in_lnkacq),
        .expired (lnk_expired),
        .first   (lnk_first)
    );

    // Next-state logic, priority: enable, signal, lock, done, window.
    always_comb begin
        ctl_d = ctl_q;
        if (!enable) begin
            ctl_d.state = ST_IDLE;
        end else if ((ctl_q.state != ST_IDLE) && !sig_det) begin
            ctl_d.state = ST_IDLE;
        end else begin
            case (ctl_q.state)
                ST_IDLE: begin
                    if (sig_det && cdr_lock) ctl_d.state = ST_DETECT;
                end
                ST_DETECT: begin
                    if (train_seen && cdr_lock) ctl_d.state = ST_CLKACQ;
                end
                ST_CLKACQ: begin
                    if (!cdr_lock)        ctl_d.state = ST_DETECT;
                    else if (xclk_done)   ctl_d.state = ST_LNKACQ;
                    else if (clk_expired) ctl_d.state = ST_DETECT;
                end
                ST_LNKACQ: begin
                    if (!cdr_lock)        ctl_d.state = ST_DETECT;
                    else if (align_done)  ctl_d.state = ST_NORMAL;
                    else if (lnk_expired) ctl_d.state = ST_DETECT;
                end
                ST_NORMAL: begin
                    if (!cdr_lock)        ctl_d.state = ST_DETECT;
                end
                default: ctl_d.state = ST_IDLE;
            endcase
        end
        ctl_d.link_up = (ctl_d.state == ST_NORMAL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state   <= ST_IDLE;
            ctl_q.link_up <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign state_code  = ctl_q.state;
    assign link_up     = ctl_q.link_up;
    assign align_start = lnk_first;

    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (state_code == 3'd0)); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_IDLE && !(sig_det && cdr_lock)) |=> (state_code == 3'd0)); // R3
    AST_BEACON_IN_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
        beacon_pulse |-> (ctl_q.state == ST_DETECT)); // R4
    AST_ALIGN_AFTER_CLKACQ: assert property (@(posedge clk) disable iff (!rst_n)
        align_start |-> ($past(ctl_q.state) == ST_CLKACQ)); // R6
    AST_LINKUP_AFTER_LNKACQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_up) |-> ($past(ctl_q.state) == ST_LNKACQ)); // R7
    AST_SIG_LOSS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !sig_det) |=> (state_code == 3'd0)); // R9
    AST_LOCK_LOSS_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && sig_det && !cdr_lock &&
         (ctl_q.state inside {ST_CLKACQ, ST_LNKACQ, ST_NORMAL})) |=> (state_code == 3'd1)); // R10

endmodule

// File: tb/sim_lnk_train_ctrl.sv
module sim_lnk_train_ctrl;
    localparam int P_BCN  = 5;
    localparam int P_CWIN = 12;
    localparam int P_LWIN = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, sig = 1'b0, lock = 1'b0, trn = 1'b0, ext = 1'b0, aln = 1'b0;
    logic beacon, astart, lup;
    logic [2:0] scode;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_req = "R1";

    int m_st = 0, m_bc = 0, m_cc = 0, m_lc = 0;

    always #5 clk = ~clk;

    lnk_train_ctrl #(
        .BEACON_PERIOD (P_BCN),
        .CLK_ACQ_WINDOW(P_CWIN),
        .LNK_ACQ_WINDOW(P_LWIN)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .enable(en), .sig_det(sig), .cdr_lock(lock),
        .train_seen(trn), .xclk_done(ext), .align_done(aln),
        .beacon_pulse(beacon), .align_start(astart), .link_up(lup), .state_code(scode)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cycles);
        end
    endtask

    function automatic int ref_next();
        if (!en) return 0;
        if (m_st != 0 && !sig) return 0;
        case (m_st)
            0: return (sig && lock) ? 1 : 0;
            1: return (trn && lock) ? 2 : 1;
            2: begin
                if (!lock) return 1;
                if (ext) return 3;
                if (m_cc == P_CWIN - 1) return 1;
                return 2;
            end
            3: begin
                if (!lock) return 1;
                if (aln) return 4;
                if (m_lc == P_LWIN - 1) return 1;
                return 3;
            end
            default: return lock ? 4 : 1;
        endcase
    endfunction

    task automatic compare_all();
        chk(cur_req, int'(scode), m_st);
        chk("R4", int'(beacon), (m_st == 1 && m_bc == 0) ? 1 : 0);
        chk("R6", int'(astart), (m_st == 3 && m_lc == 0) ? 1 : 0);
        chk("R7", int'(lup), (m_st == 4) ? 1 : 0);
    endtask

    task automatic step();
        int ns;
        int old;
        ns = ref_next();
        @(posedge clk);
        old = m_st;
        m_bc = (old == 1) ? (m_bc + 1) % P_BCN : 0;
        m_cc = (old == 2) ? ((m_cc < P_CWIN - 1) ? m_cc + 1 : m_cc) : 0;
        m_lc = (old == 3) ? ((m_lc < P_LWIN - 1) ? m_lc + 1 : m_lc) : 0;
        m_st = ns;
        @(negedge clk);
        cycles++;
        compare_all();
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic set_in(input logic e, input logic s, input logic l,
                          input logic t, input logic x, input logic a);
        en = e; sig = s; lock = l; trn = t; ext = x; aln = a;
    endtask

    task automatic reach_lnkacq();
        set_in(1, 1, 1, 0, 0, 0); step();
        set_in(1, 1, 1, 1, 0, 0); step();
        set_in(1, 1, 1, 0, 1, 0); step();
        set_in(1, 1, 1, 0, 0, 0);
    endtask

    task automatic reach_normal();
        reach_lnkacq();
        set_in(1, 1, 1, 0, 0, 1); step();
        set_in(1, 1, 1, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=done", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        cur_req = "R1";
        compare_all();
        rst_n = 1'b1;
        @(negedge clk);
        compare_all();
        chk("R1", int'(scode), 0);

        // R3: idle holds until signal and lock together
        cur_req = "R3";
        set_in(1, 1, 0, 0, 0, 0); steps(4);
        set_in(1, 0, 1, 0, 0, 0); steps(3);
        set_in(1, 1, 1, 0, 0, 0); step();
        chk("R3", int'(scode), 1);

        // R4: beacon cadence in link detect
        cur_req = "R4";
        steps(17);

        // R5 and R10: lock loss in detect keeps detect; train needs lock
        cur_req = "R5";
        set_in(1, 1, 0, 1, 0, 0); steps(3);
        chk("R5", int'(scode), 1);
        set_in(1, 1, 1, 1, 0, 0); step();
        chk("R5", int'(scode), 2);

        // R8: clock acquisition timeout
        cur_req = "R8";
        set_in(1, 1, 1, 0, 0, 0); steps(P_CWIN - 1);
        chk("R8", int'(scode), 2);
        step();
        chk("R8", int'(scode), 1);

        // R6: extraction done, align start, then link window timeout
        cur_req = "R6";
        reach_lnkacq();
        chk("R6", int'(astart), 1);
        cur_req = "R8";
        steps(P_LWIN);
        chk("R8", int'(scode), 1);

        // R8: done in the last budget cycle wins
        set_in(1, 1, 1, 0, 0, 0); step();
        reach_lnkacq();
        steps(P_LWIN - 1);
        set_in(1, 1, 1, 0, 0, 1); step();
        chk("R8", int'(scode), 4);

        // R7: normal holds with lock
        cur_req = "R7";
        set_in(1, 1, 1, 0, 0, 0); steps(10);
        chk("R7", int'(lup), 1);

        // R10: lock loss in normal
        cur_req = "R10";
        set_in(1, 1, 0, 0, 0, 0); step();
        chk("R10", int'(scode), 1);

        // R9: signal and lock lost together from normal
        cur_req = "R9";
        reach_normal();
        set_in(1, 0, 0, 0, 0, 0); step();
        chk("R9", int'(scode), 0);

        // R2: enable low forces idle and holds it
        cur_req = "R2";
        set_in(1, 1, 1, 0, 0, 0); step();
        set_in(1, 1, 1, 1, 0, 0); step();
        set_in(0, 1, 1, 1, 1, 1); steps(6);
        chk("R2", int'(scode), 0);
        chk("R2", int'(beacon), 0);

        // R11: weighted random stream against the reference model
        cur_req = "R11";
        for (int i = 0; i < 4000; i++) begin
            en   = ($urandom_range(0, 99) < 97);
            sig  = ($urandom_range(0, 99) < 95);
            lock = ($urandom_range(0, 99) < 90);
            trn  = ($urandom_range(0, 99) < 30);
            ext  = ($urandom_range(0, 99) < 12);
            aln  = ($urandom_range(0, 99) < 12);
            step();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule